// File: doc/BRIEF.md
# Fixed-Priority Arbiter with Low-Priority Starvation Guard

This block picks one winner per cycle among a set of requesters that share a resource. It runs on a fast memory clock. The lowest-numbered active requester normally wins. The result leaves the block as a registered binary code equal to the winner's number. The code is zero when nobody is asking.

A pure priority chain can lock out the last requester for as long as any higher requester stays busy. To prevent this, the block watches the last request line and counts ticks of a slower time base while that line is held. The ticks arrive as single-cycle pulses that are already synchronized to the memory clock. Once the count reaches a parameterized threshold (two ticks by default), the last requester is promoted. It takes the very next grant, ahead of every other line. After that grant, arbitration returns to plain fixed priority.

The guard can be removed by parameter, which leaves a bare registered priority encoder.

Top module: `starve_guard_arbiter`

## Requirements
- R1: Request bit i belongs to requester i+1. Among the active requests, the lowest requester number wins, unless the guard has promoted the last requester.
- R2: The grant output is the winner's number in binary. Requester 1 gives 001, requester 2 gives 010, and so on up to 111 for requester 7.
- R3: When no request bit is set, the grant output is 000.
- R4: The grant is registered. The value after a rising edge reflects the requests and the guard state sampled at that edge. During and right after reset the grant is 000.
- R5: The guard flag sets at the edge that samples the second tick seen while request 7 has been held continuously without being granted. Ticks while request 7 is low are not counted.
- R6: While the guard flag is set and request 7 is active, the next grant is 7, even if requester 1 is also asking.
- R7: Granting requester 7, whether forced or by plain priority, clears the guard flag and the tick count. The next arbitration follows plain fixed priority.
- R8: A cycle with request 7 low clears the guard flag and the tick count. A later hold starts counting again from zero.
- R9: A single tick while request 7 is held does not promote requester 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | One-cycle pulse per period of the slow time base, synchronous to clk_i |
| req_i | input | NUM_REQ (7) | Request lines; bit i is requester i+1 |
| gnt_o | output | GNT_W (3) | Registered winner number; 0 means idle |

## Verification
A tick counter that is wrong shows up at the grant port: the forced grant of 7 comes one tick too early, one tick too late, or never. The bench pins this down by checking the exact cycle after the second tick. A guard flag that fails to clear is visible within one cycle, as a second consecutive grant of 7 over requester 1. A flag that survives a dropped request is caught by a single tick after the request returns, which would then promote requester 7 too soon. A priority encoder error appears on the very next cycle as a wrong code.

// File: rtl/arb_pkg.sv
package arb_pkg;
   // number of bits needed to code 0..n
   function automatic int grant_width(input int n);
      int w;
      w = 1;
      while ((1 << w) < (n + 1)) w++;
      return w;
   endfunction
endpackage

// File: rtl/arb_prio_enc.sv
module arb_prio_enc #(
   parameter int NUM_REQ = 7,
   parameter int GNT_W   = arb_pkg::grant_width(NUM_REQ)
) (
   input  logic [NUM_REQ-1:0] req_i,
   output logic [GNT_W-1:0]   code_o
);
   // scan from the top down so the lowest index is written last and wins
   always_comb begin
      code_o = '0;
      for (int i = NUM_REQ - 1; i >= 0; i--) begin
         if (req_i[i]) code_o = GNT_W'(i + 1);
      end
   end
endmodule

// File: rtl/arb_starve_det.sv
module arb_starve_det #(
   parameter int GUARD_TICKS = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic watch_req_i,
   input  logic watch_won_i,
   output logic starve_o
);
   localparam int CNT_W = $clog2(GUARD_TICKS + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GUARD_TICKS);

   logic [CNT_W-1:0] tick_cnt_q;
   logic             starve_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tick_cnt_q <= '0;
         starve_q   <= 1'b0;
      end else if (!watch_req_i || watch_won_i) begin
         tick_cnt_q <= '0;
         starve_q   <= 1'b0;
      end else if (tick_i && !starve_q) begin
         tick_cnt_q <= tick_cnt_q + 1'b1;
         if (tick_cnt_q + 1'b1 >= LIMIT) starve_q <= 1'b1;
      end
   end

   assign starve_o = starve_q;

   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_cnt_q <= LIMIT) else $error("tick count past limit"); // R5
endmodule

// File: rtl/starve_guard_arbiter.sv
module starve_guard_arbiter #(
   parameter int NUM_REQ     = 7,
   parameter int GUARD_TICKS = 2,
   parameter bit GUARD_EN    = 1'b1,
   parameter int GNT_W       = arb_pkg::grant_width(NUM_REQ)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               slow_tick_i,
   input  logic [NUM_REQ-1:0] req_i,
   output logic [GNT_W-1:0]   gnt_o
);
   localparam int LAST = NUM_REQ - 1;
   localparam logic [GNT_W-1:0] LAST_CODE = GNT_W'(NUM_REQ);

   if (NUM_REQ < 2)                        begin : g_chk_n   $error("NUM_REQ must be at least 2"); end
   if (GUARD_TICKS < 1)                    begin : g_chk_t   $error("GUARD_TICKS must be at least 1"); end
   if (GNT_W != arb_pkg::grant_width(NUM_REQ)) begin : g_chk_w $error("GNT_W must match NUM_REQ"); end

   logic [GNT_W-1:0] prio_code;
   logic [GNT_W-1:0] winner;
   logic             starve;
   logic [GNT_W-1:0] gnt_q;

   arb_prio_enc #(.NUM_REQ(NUM_REQ), .GNT_W(GNT_W)) u_enc (
      .req_i (req_i),
      .code_o(prio_code)
   );

   if (GUARD_EN) begin : g_guard
      arb_starve_det #(.GUARD_TICKS(GUARD_TICKS)) u_det (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .tick_i     (slow_tick_i),
         .watch_req_i(req_i[LAST]),
         .watch_won_i(winner == LAST_CODE),
         .starve_o   (starve)
      );
   end else begin : g_plain
      assign starve = 1'b0;
   end

   // promotion overrides the chain only while the watched line still asks
   always_comb begin
      winner = prio_code;
      if (starve && req_i[LAST]) winner = LAST_CODE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gnt_q <= '0;
      else         gnt_q <= winner;
   end

   assign gnt_o = gnt_q;

   AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i == '0) |=> (gnt_o == '0)) else $error("grant without request"); // R3
   AST_TOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[0] && !starve) |=> (gnt_o == GNT_W'(1))) else $error("requester 1 lost"); // R1
   AST_PROMOTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (starve && req_i[LAST]) |=> (gnt_o == LAST_CODE)) else $error("promotion missed"); // R6
   AST_CLEAR_ON_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o == LAST_CODE) |-> !starve) else $error("flag kept after grant"); // R7
   AST_CLEAR_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i[LAST] |=> !starve) else $error("flag kept after drop"); // R8
endmodule

// File: tb/tb_starve_guard_arbiter.sv
module tb_starve_guard_arbiter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [6:0] req = '0;
   logic [2:0] gnt;

   int n_checks = 0;
   int n_fail   = 0;
   logic [2:0] exp_q[$];
   string      tag_q[$];
   bit         done = 1'b0;

   always #5 clk = ~clk;

   starve_guard_arbiter dut (
      .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(tick), .req_i(req), .gnt_o(gnt)
   );

   task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: gnt=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // driver: apply one cycle of stimulus and queue the grant it must produce
   task automatic drive(input logic [6:0] r, input logic t, input logic [2:0] exp, input string tag);
      @(negedge clk);
      req  = r;
      tick = t;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   // monitor: compare just after every edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) check(gnt, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(gnt, 3'd0, "R4 reset");
      rst_n = 1'b1;
      // plain priority
      drive(7'b0000000, 0, 3'd0, "R3 idle");
      drive(7'b0000001, 0, 3'd1, "R1 single");
      drive(7'b1111110, 0, 3'd2, "R1 lowest wins");
      drive(7'b1000100, 1, 3'd3, "R2 code 3");
      drive(7'b0010000, 0, 3'd5, "R2 code 5");
      drive(7'b1000000, 1, 3'd7, "R2 code 7");
      drive(7'b1000000, 1, 3'd7, "R7 natural grant resets count");
      drive(7'b0000000, 0, 3'd0, "R3 idle again");
      // starvation sequence, requester 1 busy throughout
      drive(7'b1000001, 0, 3'd1, "R1 hold");
      drive(7'b1000001, 1, 3'd1, "R9 first tick");
      drive(7'b1000001, 0, 3'd1, "R9 no promotion");
      drive(7'b1000001, 0, 3'd1, "R9 still none");
      drive(7'b1000001, 1, 3'd1, "R5 second tick sets flag");
      drive(7'b1000001, 0, 3'd7, "R6 forced grant");
      drive(7'b1000001, 0, 3'd1, "R7 back to priority");
      drive(7'b1000001, 1, 3'd1, "R7 count restarted");
      drive(7'b1000001, 0, 3'd1, "R7 one tick only");
      drive(7'b1000001, 1, 3'd1, "R5 flag set again");
      drive(7'b0000001, 0, 3'd1, "R8 drop with flag");
      drive(7'b1000001, 1, 3'd1, "R8 flag cleared by drop");
      drive(7'b1000001, 0, 3'd1, "R8 single tick");
      drive(7'b1000001, 1, 3'd1, "R5 second tick");
      drive(7'b1000011, 0, 3'd7, "R6 over requesters 1 and 2");
      // ticks while line 7 low do not count
      drive(7'b0000010, 1, 3'd2, "R5 tick with 7 low");
      drive(7'b1000010, 1, 3'd2, "R5 first counted tick");
      drive(7'b1000010, 0, 3'd2, "R9 not yet");
      // reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(gnt, 3'd0, "R4 async reset");
      @(negedge clk);
      rst_n = 1'b1;
      req = '0;
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish");
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule